// File: doc/BRIEF.md
# Memory Pattern Fill-Verify Sequencer

This block is a built-in self-test engine for a memory made of 32-bit words. It reaches the memory through a simple synchronous port: a request is presented on one clock edge, and read data comes back on the next edge. On a start pulse it runs seven test passes in a fixed order. Each pass first writes every word of the area under test with a generated value. It then reads the whole area back and compares each word with the value it expects. The run stops at the first word that reads back wrong. The failing word address, the value expected and the value actually read are then held for software or a test controller to collect.

Two coverage modes are offered. Full mode treats the whole region as a single window. Sampled mode visits only a pair of short windows at every whole segment of the region, one at the start of the segment and one ending at its top edge. This gives quick coverage of every segment boundary at a small fraction of the run time. While a run is in progress, a heartbeat pulse marks steady progress through the memory, so that an external watchdog can be serviced.

Top module: `mfv_seq`

## Requirements
- R1: Each window is tested with seven passes in this order. The first four use a constant value: 0x00000000, then 0xFFFFFFFF, then 0x55555555, then 0xAAAAAAAA. The fifth writes a single set bit at position (k mod 32). The sixth writes k, and the seventh writes the bitwise inverse of k.
- R2: Within a pass, every word of the window is written before the first read of that pass is issued. Both the writes and the reads walk the window in ascending address order, one operation per cycle.
- R3: The value k used by the walking-bit and index passes is the word's offset from the start of the current window, not its absolute address.
- R4: With full_mode=1, a single window starting at region_base and spanning region_words words is tested. A region of zero words finishes at once without failure.
- R5: With full_mode=0, let n = floor(region_words / 2^SEG_LOG). For each segment i from 0 to n-1, two windows of 2^WIN_LOG words are tested. The first starts at region_base + i·2^SEG_LOG. The second ends exactly at region_base + (i+1)·2^SEG_LOG. Words of a partial segment are never touched, and when n = 0 the run finishes with no memory access.
- R6: The first read whose data differs from the expected word ends the run. No further memory operation is issued, no later pass or window is started, and `failed` is set. The report gives the word address, the expected word and the word read.
- R7: `failed` and the three report fields hold their values until the next accepted start, which clears them.
- R8: `heartbeat` is a one-cycle pulse. It is raised together with any write or read whose window offset is a multiple of 2^HB_LOG.
- R9: Read data is taken from `mem_rdata` one cycle after the read request. No access ever falls outside [region_base, region_base + region_words).
- R10: After reset, busy, done, failed and mem_en are 0. `busy` rises in the cycle after an accepted start and stays high until the run ends. The run ends with a one-cycle `done` pulse, during which `busy` is already 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run; accepted only when idle |
| full_mode | input | 1 | 1 = whole region, 0 = sampled segment windows |
| region_base | input | ADDR_W | First word address of the region |
| region_words | input | ADDR_W+1 | Region size in words |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| failed | output | 1 | Last run hit a mismatch |
| fail_addr | output | ADDR_W | Word address of the mismatch |
| fail_expect | output | 32 | Word the pass expected |
| fail_read | output | 32 | Word read back |
| heartbeat | output | 1 | Progress pulse |
| mem_en | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |

## Verification
The compare of the last read of a pass falls in the same cycle in which the engine would otherwise decide to move on to the next pass or window. To provoke this, a stuck bit is placed on the final word of a window, so the mismatch appears exactly on that drain cycle. The bench then requires that the failure wins: the operation count must stop at one full write sweep plus one read sweep, and the report must name that last word. A second fault aliases two addresses 32 words apart. Because they are 32 words apart, the walking-bit pass cannot see it, and the index pass must be the one to catch it. This confirms the pass order and that the offset is relative to the window.

// File: rtl/mfv_pkg.sv
package mfv_pkg;

    typedef enum logic [2:0] {
        PS_ZERO   = 3'd0,
        PS_ONES   = 3'd1,
        PS_FIVES  = 3'd2,
        PS_AS     = 3'd3,
        PS_WALK   = 3'd4,
        PS_INDEX  = 3'd5,
        PS_NINDEX = 3'd6
    } pass_e;

    localparam pass_e PASS_FINAL = PS_NINDEX;

    typedef enum logic [1:0] {
        EN_IDLE,
        EN_WRITE,
        EN_READ,
        EN_DRAIN
    } eng_st_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_LAUNCH,
        SQ_WAIT
    } seq_st_e;

    typedef struct packed {
        logic [31:0] expect_w;
        logic [31:0] read_w;
    } cmp_pair_t;

    function automatic logic [31:0] pass_word(pass_e p, logic [31:0] ofs);
        logic [31:0] w;
        case (p)
            PS_ZERO:   w = 32'h0000_0000;
            PS_ONES:   w = 32'hFFFF_FFFF;
            PS_FIVES:  w = 32'h5555_5555;
            PS_AS:     w = 32'hAAAA_AAAA;
            PS_WALK:   w = 32'd1 << ofs[4:0];
            PS_INDEX:  w = ofs;
            default:   w = ~ofs;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/mfv_window_gen.sv
module mfv_window_gen
    import mfv_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int SEG_LOG = 18,
    parameter int WIN_LOG = 9
) (
    input  logic              full_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W:0]   words_i,
    input  logic [ADDR_W:0]   win_idx_i,
    output logic [ADDR_W-1:0] win_base_o,
    output logic [ADDR_W:0]   win_len_o,
    output logic              win_last_o,
    output logic              any_o
);
    localparam int CNT_W = ADDR_W + 1;
    localparam logic [CNT_W-1:0] SEG_WORDS = CNT_W'(1) << SEG_LOG;
    localparam logic [CNT_W-1:0] WIN_WORDS = CNT_W'(1) << WIN_LOG;
    localparam logic [CNT_W-1:0] TOP_OFS   = SEG_WORDS - WIN_WORDS;

    logic [CNT_W-1:0] n_seg;
    logic [CNT_W-1:0] n_win;
    logic [CNT_W-1:0] seg_ofs;
    logic [CNT_W-1:0] ofs;

    always_comb begin
        n_seg   = words_i >> SEG_LOG;
        n_win   = full_i ? ((words_i != '0) ? CNT_W'(1) : '0) : (n_seg << 1);
        seg_ofs = (win_idx_i >> 1) << SEG_LOG;
        ofs     = full_i ? '0 : (seg_ofs + (win_idx_i[0] ? TOP_OFS : '0));
        win_base_o = base_i + ADDR_W'(ofs);
        win_len_o  = full_i ? words_i : WIN_WORDS;
        win_last_o = (win_idx_i + CNT_W'(1)) == n_win;
        any_o      = n_win != '0;
    end

endmodule

// File: rtl/mfv_pass_engine.sv
module mfv_pass_engine
    import mfv_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int HB_LOG = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W:0]   len_i,
    output logic              done_o,
    output logic              fail_o,
    output logic [ADDR_W-1:0] fail_addr_o,
    output cmp_pair_t         fail_pair_o,
    output logic              hb_o,
    output logic              mem_en_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [31:0]       mem_wdata_o,
    input  logic [31:0]       mem_rdata_i
);
    localparam int CNT_W = ADDR_W + 1;

    eng_st_e           st_q;
    pass_e             pass_q;
    logic [CNT_W-1:0]  idx_q;
    logic [CNT_W-1:0]  len_q;
    logic [ADDR_W-1:0] base_q;
    logic              rd_v_q;
    logic [31:0]       rd_exp_q;
    logic [ADDR_W-1:0] rd_addr_q;

    logic              mismatch;
    logic              idx_end;
    logic              issue;
    logic [31:0]       cur_word;

    always_comb begin
        mismatch = rd_v_q && (mem_rdata_i != rd_exp_q);
        idx_end  = idx_q == (len_q - CNT_W'(1));
        cur_word = pass_word(pass_q, 32'(idx_q));
        issue    = (st_q == EN_WRITE) || ((st_q == EN_READ) && !mismatch);
        mem_en_o    = issue;
        mem_we_o    = st_q == EN_WRITE;
        mem_addr_o  = base_q + ADDR_W'(idx_q);
        mem_wdata_o = (st_q == EN_WRITE) ? cur_word : '0;
        hb_o        = issue && (idx_q[HB_LOG-1:0] == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= EN_IDLE;
            pass_q      <= PS_ZERO;
            idx_q       <= '0;
            len_q       <= '0;
            base_q      <= '0;
            rd_v_q      <= 1'b0;
            rd_exp_q    <= '0;
            rd_addr_q   <= '0;
            done_o      <= 1'b0;
            fail_o      <= 1'b0;
            fail_addr_o <= '0;
            fail_pair_o <= '0;
        end else begin
            done_o <= 1'b0;
            rd_v_q <= 1'b0;
            if (mismatch) begin
                st_q        <= EN_IDLE;
                done_o      <= 1'b0 | 1'b1;
                fail_o      <= 1'b1;
                fail_addr_o <= rd_addr_q;
                fail_pair_o <= '{expect_w: rd_exp_q, read_w: mem_rdata_i};
            end else begin
                case (st_q)
                    EN_IDLE: begin
                        if (start_i) begin
                            st_q   <= EN_WRITE;
                            pass_q <= PS_ZERO;
                            idx_q  <= '0;
                            len_q  <= len_i;
                            base_q <= base_i;
                            fail_o <= 1'b0;
                        end
                    end
                    EN_WRITE: begin
                        idx_q <= idx_end ? '0 : idx_q + CNT_W'(1);
                        if (idx_end) st_q <= EN_READ;
                    end
                    EN_READ: begin
                        rd_v_q    <= 1'b1;
                        rd_exp_q  <= cur_word;
                        rd_addr_q <= mem_addr_o;
                        idx_q     <= idx_q + CNT_W'(1);
                        if (idx_end) st_q <= EN_DRAIN;
                    end
                    default: begin
                        idx_q <= '0;
                        if (pass_q == PASS_FINAL) begin
                            st_q   <= EN_IDLE;
                            done_o <= 1'b1;
                        end else begin
                            pass_q <= pass_e'(pass_q + 3'd1);
                            st_q   <= EN_WRITE;
                        end
                    end
                endcase
            end
        end
    end

    a_r2_no_write_after_read: assert property (@(posedge clk) disable iff (rst)
        (mem_en_o && !mem_we_o) |=> !(mem_en_o && mem_we_o));

    a_r6_halt_on_mismatch: assert property (@(posedge clk) disable iff (rst)
        (rd_v_q && (mem_rdata_i != rd_exp_q)) |=> !mem_en_o);

    a_r1_first_write_zero: assert property (@(posedge clk) disable iff (rst)
        (start_i && st_q == EN_IDLE) |=> (mem_we_o && mem_wdata_o == 32'h0));

endmodule

// File: rtl/mfv_seq.sv
module mfv_seq
    import mfv_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int SEG_LOG = 18,
    parameter int WIN_LOG = 9,
    parameter int HB_LOG  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              full_mode,
    input  logic [ADDR_W-1:0] region_base,
    input  logic [ADDR_W:0]   region_words,
    output logic              busy,
    output logic              done,
    output logic              failed,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [31:0]       fail_expect,
    output logic [31:0]       fail_read,
    output logic              heartbeat,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata
);
    localparam int CNT_W = ADDR_W + 1;

    seq_st_e           st_q;
    logic              full_q;
    logic [ADDR_W-1:0] base_q;
    logic [CNT_W-1:0]  words_q;
    logic [CNT_W-1:0]  win_idx_q;
    logic              eng_start_q;

    logic [ADDR_W-1:0] win_base;
    logic [CNT_W-1:0]  win_len;
    logic              win_last;
    logic              win_any;
    logic              eng_done;
    logic              eng_fail;
    logic [ADDR_W-1:0] eng_fail_addr;
    cmp_pair_t         eng_pair;

    mfv_window_gen #(
        .ADDR_W (ADDR_W),
        .SEG_LOG(SEG_LOG),
        .WIN_LOG(WIN_LOG)
    ) win_i (
        .full_i    (full_q),
        .base_i    (base_q),
        .words_i   (words_q),
        .win_idx_i (win_idx_q),
        .win_base_o(win_base),
        .win_len_o (win_len),
        .win_last_o(win_last),
        .any_o     (win_any)
    );

    mfv_pass_engine #(
        .ADDR_W(ADDR_W),
        .HB_LOG(HB_LOG)
    ) eng_i (
        .clk        (clk),
        .rst        (rst),
        .start_i    (eng_start_q),
        .base_i     (win_base),
        .len_i      (win_len),
        .done_o     (eng_done),
        .fail_o     (eng_fail),
        .fail_addr_o(eng_fail_addr),
        .fail_pair_o(eng_pair),
        .hb_o       (heartbeat),
        .mem_en_o   (mem_en),
        .mem_we_o   (mem_we),
        .mem_addr_o (mem_addr),
        .mem_wdata_o(mem_wdata),
        .mem_rdata_i(mem_rdata)
    );

    assign busy = st_q != SQ_IDLE;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= SQ_IDLE;
            full_q      <= 1'b0;
            base_q      <= '0;
            words_q     <= '0;
            win_idx_q   <= '0;
            eng_start_q <= 1'b0;
            done        <= 1'b0;
            failed      <= 1'b0;
            fail_addr   <= '0;
            fail_expect <= '0;
            fail_read   <= '0;
        end else begin
            done        <= 1'b0;
            eng_start_q <= 1'b0;
            case (st_q)
                SQ_IDLE: begin
                    if (start) begin
                        full_q      <= full_mode;
                        base_q      <= region_base;
                        words_q     <= region_words;
                        win_idx_q   <= '0;
                        failed      <= 1'b0;
                        fail_addr   <= '0;
                        fail_expect <= '0;
                        fail_read   <= '0;
                        st_q        <= SQ_LAUNCH;
                    end
                end
                SQ_LAUNCH: begin
                    if (!win_any) begin
                        done <= 1'b1;
                        st_q <= SQ_IDLE;
                    end else begin
                        eng_start_q <= 1'b1;
                        st_q        <= SQ_WAIT;
                    end
                end
                default: begin
                    if (eng_done) begin
                        if (eng_fail) begin
                            failed      <= 1'b1;
                            fail_addr   <= eng_fail_addr;
                            fail_expect <= eng_pair.expect_w;
                            fail_read   <= eng_pair.read_w;
                            done        <= 1'b1;
                            st_q        <= SQ_IDLE;
                        end else if (win_last) begin
                            done <= 1'b1;
                            st_q <= SQ_IDLE;
                        end else begin
                            win_idx_q <= win_idx_q + CNT_W'(1);
                            st_q      <= SQ_LAUNCH;
                        end
                    end
                end
            endcase
        end
    end

    a_r9_inside_region: assert property (@(posedge clk) disable iff (rst)
        mem_en |-> ((mem_addr >= base_q) &&
                    ({1'b0, mem_addr} - {1'b0, base_q} < words_q)));

    a_r7_report_held: assert property (@(posedge clk) disable iff (rst)
        (failed && !start) |=> (failed && $stable(fail_addr) && $stable(fail_read)));

    a_r10_done_when_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r8_heartbeat_single: assert property (@(posedge clk) disable iff (rst)
        heartbeat |-> mem_en);

endmodule

// File: tb/mfv_seq_tb.sv
module mfv_seq_tb_top;

    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic          full_mode;
    logic [AW-1:0] region_base;
    logic [AW:0]   region_words;
    logic          busy, done, failed, heartbeat;
    logic [AW-1:0] fail_addr;
    logic [31:0]   fail_expect, fail_read;
    logic          mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata, mem_rdata;

    always #2.5 clk = ~clk;

    mfv_seq #(.ADDR_W(AW), .SEG_LOG(6), .WIN_LOG(3), .HB_LOG(4)) dut_i (
        .clk(clk), .rst(rst), .start(start), .full_mode(full_mode),
        .region_base(region_base), .region_words(region_words),
        .busy(busy), .done(done), .failed(failed), .fail_addr(fail_addr),
        .fail_expect(fail_expect), .fail_read(fail_read), .heartbeat(heartbeat),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // memory model with fault injection
    logic [31:0] mem [0:(1<<AW)-1];
    logic        st_en, al_en;
    logic [AW-1:0] st_addr, al_src, al_dst;
    logic [31:0] st_mask;

    always @(posedge clk) begin
        logic [31:0] rv;
        if (mem_en) begin
            if (mem_we) begin
                mem[mem_addr] <= mem_wdata;
                if (al_en && mem_addr == al_src) mem[al_dst] <= mem_wdata;
            end else begin
                rv = mem[mem_addr];
                if (st_en && mem_addr == st_addr) rv = rv | st_mask;
                mem_rdata <= rv;
            end
        end
    end

    // expected operation list
    bit          e_we   [0:1023];
    int          e_addr [0:1023];
    logic [31:0] e_data [0:1023];
    int n_exp, op_cnt, hb_cnt, seq_bad, bad_at;
    int checks = 0, fails = 0;
    bit finished = 0;

    function automatic logic [31:0] expw(int p, int k);
        case (p)
            0: return 32'h0;
            1: return 32'hFFFFFFFF;
            2: return 32'h55555555;
            3: return 32'hAAAAAAAA;
            4: return 32'h1 << (k % 32);
            5: return 32'(k);
            default: return ~32'(k);
        endcase
    endfunction

    task automatic add_window(int b, int len);
        for (int p = 0; p < 7; p++) begin
            for (int i = 0; i < len; i++) begin
                e_we[n_exp] = 1; e_addr[n_exp] = b + i; e_data[n_exp] = expw(p, i); n_exp++;
            end
            for (int i = 0; i < len; i++) begin
                e_we[n_exp] = 0; e_addr[n_exp] = b + i; e_data[n_exp] = 0; n_exp++;
            end
        end
    endtask

    task automatic build_seq(bit full, int b, int w);
        n_exp = 0;
        if (full) begin
            if (w > 0) add_window(b, w);
        end else begin
            for (int s = 0; s < w / 64; s++) begin
                add_window(b + s * 64, 8);
                add_window(b + s * 64 + 56, 8);
            end
        end
    endtask

    always @(negedge clk) begin
        if (mem_en) begin
            if (op_cnt >= n_exp || mem_we != e_we[op_cnt] || int'(mem_addr) != e_addr[op_cnt] ||
                (mem_we && mem_wdata != e_data[op_cnt])) begin
                if (seq_bad == 0) bad_at = op_cnt;
                seq_bad++;
            end
            op_cnt++;
        end
        if (heartbeat) hb_cnt++;
    end

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run(bit full, int b, int w);
        int cyc;
        build_seq(full, b, w);
        op_cnt = 0; hb_cnt = 0; seq_bad = 0; bad_at = -1;
        @(negedge clk);
        full_mode = full; region_base = AW'(b); region_words = (AW+1)'(w); start = 1;
        @(negedge clk);
        start = 0;
        check(busy === 1'b1 && failed === 1'b0, "R10", "busy/failed cleared after start",
              {busy, failed}, 2);
        cyc = 0;
        while (done !== 1'b1 && cyc < 20000) begin
            @(negedge clk); cyc++;
        end
        check(done === 1'b1 && busy === 1'b0, "R10", "done pulse while idle", {done, busy}, 2);
    endtask

    task automatic clear_faults();
        st_en = 0; al_en = 0; st_addr = 0; al_src = 0; al_dst = 0; st_mask = 0;
    endtask

    task automatic t_reset();
        check(busy === 0 && done === 0 && failed === 0 && mem_en === 0, "R10", "reset state",
              {busy, done, failed, mem_en}, 0);
    endtask

    task automatic t_full_clean();
        clear_faults();
        run(1, 'h20, 64);
        check(failed === 0, "R4", "full clean run not failed", failed, 0);
        check(seq_bad == 0, "R1", "pattern/order sequence, first bad op index", bad_at, -1);
        check(op_cnt == 896, "R2", "full op count", op_cnt, 896);
        check(hb_cnt == 56, "R8", "heartbeat count full", hb_cnt, 56);
    endtask

    task automatic t_region_two_seg();
        clear_faults();
        run(0, 'h100, 128);
        check(failed === 0, "R5", "region clean run", failed, 0);
        check(seq_bad == 0, "R3", "window-relative offsets, first bad op", bad_at, -1);
        check(op_cnt == 448, "R5", "region two-segment op count", op_cnt, 448);
        check(hb_cnt == 56, "R8", "heartbeat count region", hb_cnt, 56);
    endtask

    task automatic t_region_partial();
        clear_faults();
        run(0, 'h100, 100);
        check(seq_bad == 0 && op_cnt == 224, "R5", "partial segment ignored, op count", op_cnt, 224);
        run(0, 'h100, 40);
        check(op_cnt == 0 && failed === 0, "R5", "under one segment: no access", op_cnt, 0);
        run(1, 'h100, 0);
        check(op_cnt == 0 && failed === 0, "R4", "empty full region: no access", op_cnt, 0);
    endtask

    task automatic t_last_word_fault();
        clear_faults();
        st_en = 1; st_addr = AW'('h23F); st_mask = 32'h20;
        run(1, 'h200, 64);
        check(failed === 1, "R6", "last-word stuck bit fails", failed, 1);
        check(fail_addr == 'h23F, "R6", "fail address", fail_addr, 'h23F);
        check(fail_expect == 0 && fail_read == 32'h20, "R6", "expect/read words",
              fail_read, 32'h20);
        check(op_cnt == 128 && seq_bad == 0, "R6", "no op after last-word mismatch", op_cnt, 128);
        repeat (20) @(negedge clk);
        check(failed === 1 && fail_addr == 'h23F && fail_read == 32'h20, "R7",
              "report held while idle", fail_addr, 'h23F);
    endtask

    task automatic t_alias_fault();
        clear_faults();
        al_en = 1; al_src = AW'('h328); al_dst = AW'('h308);
        run(1, 'h300, 64);
        check(failed === 1 && fail_addr == 'h308, "R3", "alias caught at index pass addr",
              fail_addr, 'h308);
        check(fail_expect == 8 && fail_read == 'h28, "R1", "index pass expect/read",
              fail_read, 'h28);
        check(op_cnt == 713 && seq_bad == 0, "R6", "stop at first mismatch, op count",
              op_cnt, 713);
    endtask

    task automatic t_region_fault();
        clear_faults();
        st_en = 1; st_addr = AW'('h17B); st_mask = 32'h1;
        run(0, 'h100, 128);
        check(failed === 1 && fail_addr == 'h17B, "R5", "fault in top window of seg 1",
              fail_addr, 'h17B);
        check(fail_expect == 0 && fail_read == 1, "R9", "read data one cycle after request",
              fail_read, 1);
        check(op_cnt == 348 && seq_bad == 0, "R6", "later windows skipped", op_cnt, 348);
    endtask

    initial begin
        rst = 1; start = 0; full_mode = 0; region_base = 0; region_words = 0;
        clear_faults();
        n_exp = 0; op_cnt = 0; hb_cnt = 0; seq_bad = 0; bad_at = -1;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_full_clean();
        t_region_two_seg();
        t_region_partial();
        t_last_word_fault();
        t_alias_fault();
        t_region_fault();
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule